// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A counter of parameterised width counts down from a programmable reload value. It steps either on every system clock cycle or on a one-cycle strobe from a slow external time base. When it passes zero with a nonzero reload value, it reloads itself and keeps running, so the channel produces a regular period.

Two compare registers mark points inside each period. The channel raises an event when the count reaches the larger compare value, and another when it reaches the smaller one. Which register holds which value does not matter. Whether the zero crossing raises an event depends on configuration. Each event inverts a level-type interrupt output, so an interrupt controller that is sensitive to edges sees one edge per event.

Software-facing decoding and any shared control register sit outside this block. The block receives plain write strobes and a write data bus.

Top module: `dmt_channel`

## Requirements
- R1: After reset, `count_o` and `irq_o` are 0, and the reload and both compare registers hold 0. An enable with no prior writes therefore leaves the count at 0.
- R2: In the first cycle in which `en_i` is high after having been low, the count is loaded with the reload register. After that it decrements by one on each selected tick.
- R3: When `ext_sel_i` is 0, a tick occurs every clock cycle. When `ext_sel_i` is 1, a tick occurs only in cycles where `ext_tick_i` is 1.
- R4: A tick at count 0 loads the reload value if that value is nonzero. If the reload value is zero, the count stays at 0.
- R5: A tick that moves the count to a nonzero value equal to either compare register is an event. Both compare values therefore fire once per period, larger value first, whatever their register order. Equal compare values give a single event.
- R6: A tick that moves the count from 1 to 0 is an event only if `ovf_irq_en_i` is 1 or a compare register holds 0. Reloading from 0, enable loads and register writes are never events.
- R7: Each event inverts `irq_o` on the same clock edge that updates the count.
- R8: A write to the count register while enabled replaces the count on the next edge. This write has priority over ticks and over reload loading. While disabled, such a write has no effect.
- R9: A reload write always updates the reload register. It also loads the count only if the channel is enabled, the old reload value was 0 and the new value is nonzero.
- R10: While `en_i` is low, the count holds and `irq_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel run enable |
| ext_sel_i | input | 1 | 1 selects the external tick strobe, 0 selects every clock cycle |
| ovf_irq_en_i | input | 1 | Allows an event at the zero crossing |
| ext_tick_i | input | 1 | One-cycle external tick strobe, synchronous to clk_i |
| wr_data_i | input | CNT_W | Write data for all register writes |
| wr_count_i | input | 1 | Write strobe for the live count |
| wr_reload_i | input | 1 | Write strobe for the reload register |
| wr_match_a_i | input | 1 | Write strobe for compare register A |
| wr_match_b_i | input | 1 | Write strobe for compare register B |
| count_o | output | CNT_W | Live count value |
| irq_o | output | 1 | Interrupt level, inverted on each event |

## Verification
Every result of the channel is one register stage away from its cause. The count, the interrupt level and the reload and compare registers all change on the first rising edge after the cycle that presents the stimulus. An enable load, a write or a tick is therefore visible one full cycle later, and an event's inversion of `irq_o` coincides with the count reaching its new value.

The bench applies every input at a falling edge. It then advances whole cycles and samples both outputs at the following falling edge, so each sample lands after exactly the number of edges that the stimulus needs. Sequences through a full period step one cycle at a time. At each step, the expected count and interrupt level come from the compare values and the zero rule.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

   // How the count register is updated in a given cycle, highest priority first
   typedef enum logic [2:0] {
      CNT_HOLD   = 3'd0,
      CNT_START  = 3'd1,
      CNT_WRITE  = 3'd2,
      CNT_ARM    = 3'd3,
      CNT_DEC    = 3'd4,
      CNT_WRAP   = 3'd5,
      CNT_STUCK  = 3'd6
   } cnt_sel_e;

   // Tick source choice
   typedef enum logic {
      TICK_BUS = 1'b0,
      TICK_EXT = 1'b1
   } tick_src_e;

   localparam int unsigned MIN_CNT_W = 2;
   localparam int unsigned MAX_CNT_W = 64;
   localparam int unsigned N_MATCH   = 2;

endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel
   import dmt_pkg::*;
#(
   parameter bit EXT_TICK_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ext_sel_i,
   input  logic ext_tick_i,
   output logic tick_o
);

   generate
      if (EXT_TICK_EN) begin : g_ext
         tick_src_e src;
         always_comb begin
            src = ext_sel_i ? TICK_EXT : TICK_BUS;
            unique case (src)
               TICK_EXT: tick_o = ext_tick_i;
               default:  tick_o = 1'b1;
            endcase
         end

         // R3: external mode only ticks on a strobe
         p_ext_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ext_sel_i && !ext_tick_i) |-> !tick_o);
      end else begin : g_bus
         logic unused_sel;
         assign unused_sel = ext_sel_i ^ ext_tick_i;
         assign tick_o = 1'b1;
      end
   endgenerate

   // R3: bus-clock mode ticks every cycle
   p_bus_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ext_sel_i |-> tick_o);

endmodule

// File: rtl/dmt_cfg_regs.sv
module dmt_cfg_regs
   import dmt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             wr_reload_i,
   input  logic             wr_match_a_i,
   input  logic             wr_match_b_i,
   output logic [CNT_W-1:0] reload_o,
   output logic [CNT_W-1:0] match_a_o,
   output logic [CNT_W-1:0] match_b_o,
   output logic             reload_arm_o
);

   logic [CNT_W-1:0] reload_q;
   logic [N_MATCH-1:0] match_we;
   logic [CNT_W-1:0] match_q [N_MATCH];

   assign match_we = {wr_match_b_i, wr_match_a_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= '0;
      end else if (wr_reload_i) begin
         reload_q <= wr_data_i;
      end
   end

   generate
      for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_match
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               match_q[gi] <= '0;
            end else if (match_we[gi]) begin
               match_q[gi] <= wr_data_i;
            end
         end
      end
   endgenerate

   // A reload write only starts the count when leaving a zero reload
   assign reload_arm_o = wr_reload_i && en_i && (reload_q == '0) && (wr_data_i != '0);

   assign reload_o  = reload_q;
   assign match_a_o = match_q[0];
   assign match_b_o = match_q[1];

   // R9: reload register always takes the written value
   p_reload_upd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_reload_i |=> (reload_q == $past(wr_data_i)));

   // R1/R5: compare registers only move on their own strobe
   p_match_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_match_a_i && !wr_match_b_i) |=> ($stable(match_q[0]) && $stable(match_q[1])));

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
   import dmt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             wr_count_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             reload_arm_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] nxt_o,
   output logic             step_o
);

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             at_zero;
   cnt_sel_e         sel;

   assign at_zero = (cnt_q == '0);
   assign nxt_o   = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};

   always_comb begin
      if (!en_i)                sel = CNT_HOLD;
      else if (!en_q)           sel = CNT_START;
      else if (wr_count_i)      sel = CNT_WRITE;
      else if (reload_arm_i)    sel = CNT_ARM;
      else if (!tick_i)         sel = CNT_HOLD;
      else if (!at_zero)        sel = CNT_DEC;
      else if (reload_i != '0)  sel = CNT_WRAP;
      else                      sel = CNT_STUCK;
   end

   always_comb begin
      unique case (sel)
         CNT_START: cnt_d = reload_i;
         CNT_WRITE: cnt_d = wr_data_i;
         CNT_ARM:   cnt_d = wr_data_i;
         CNT_DEC:   cnt_d = nxt_o;
         CNT_WRAP:  cnt_d = reload_i;
         CNT_STUCK: cnt_d = '0;
         default:   cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         en_q  <= en_i;
      end
   end

   assign step_o  = (sel == CNT_DEC);
   assign count_o = cnt_q;

   // R2: enable rising loads the reload value
   p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !en_q) |=> (cnt_q == $past(reload_i)));

   // R2: plain tick from nonzero decrements by one
   p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && en_q && !wr_count_i && !reload_arm_i && tick_i && !at_zero)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4: tick at zero reloads or stays at zero
   p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && en_q && !wr_count_i && !reload_arm_i && tick_i && at_zero)
      |=> (cnt_q == $past(reload_i)));

   // R8: count write while running takes effect next edge
   p_wr_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && en_q && wr_count_i) |=> (cnt_q == $past(wr_data_i)));

   // R10: disabled channel holds its count
   p_hold_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/dmt_event.sv
module dmt_event
   import dmt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic [CNT_W-1:0] nxt_i,
   input  logic [CNT_W-1:0] match_a_i,
   input  logic [CNT_W-1:0] match_b_i,
   input  logic             ovf_irq_en_i,
   output logic             irq_o
);

   logic [CNT_W-1:0] hi_val;
   logic [CNT_W-1:0] lo_val;
   logic             hit_hi;
   logic             hit_lo;
   logic             zero_ok;
   logic             evt;
   logic             irq_q;

   // Order the two compare values so the larger one is met first
   always_comb begin
      if (match_a_i >= match_b_i) begin
         hi_val = match_a_i;
         lo_val = match_b_i;
      end else begin
         hi_val = match_b_i;
         lo_val = match_a_i;
      end
   end

   assign hit_hi  = (nxt_i == hi_val);
   assign hit_lo  = (nxt_i == lo_val);
   assign zero_ok = ovf_irq_en_i || (lo_val == '0);

   always_comb begin
      if (!step_i)            evt = 1'b0;
      else if (nxt_i != '0)   evt = hit_hi || hit_lo;
      else                    evt = zero_ok;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else if (evt) begin
         irq_q <= ~irq_q;
      end
   end

   assign irq_o = irq_q;

   // R5: reaching either compare value toggles the line
   p_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && (nxt_i != '0) && ((nxt_i == match_a_i) || (nxt_i == match_b_i)))
      |=> (irq_q != $past(irq_q)));

   // R6: zero crossing is silent without overflow enable or a zero compare
   p_zero_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && (nxt_i == '0) && !ovf_irq_en_i && (match_a_i != '0) && (match_b_i != '0))
      |=> $stable(irq_q));

   // R7: no step, no change of level
   p_no_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> $stable(irq_q));

endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
   import dmt_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter bit          EXT_TICK_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             ext_sel_i,
   input  logic             ovf_irq_en_i,
   input  logic             ext_tick_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             wr_count_i,
   input  logic             wr_reload_i,
   input  logic             wr_match_a_i,
   input  logic             wr_match_b_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   generate
      if (CNT_W < MIN_CNT_W || CNT_W > MAX_CNT_W) begin : g_bad_width
         $error("dmt_channel: CNT_W out of supported range");
      end
   endgenerate

   logic             tick;
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] match_a;
   logic [CNT_W-1:0] match_b;
   logic             reload_arm;
   logic [CNT_W-1:0] nxt;
   logic             step;

   dmt_tick_sel #(.EXT_TICK_EN(EXT_TICK_EN)) u_tick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ext_sel_i  (ext_sel_i),
      .ext_tick_i (ext_tick_i),
      .tick_o     (tick)
   );

   dmt_cfg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_i),
      .wr_data_i    (wr_data_i),
      .wr_reload_i  (wr_reload_i),
      .wr_match_a_i (wr_match_a_i),
      .wr_match_b_i (wr_match_b_i),
      .reload_o     (reload_val),
      .match_a_o    (match_a),
      .match_b_o    (match_b),
      .reload_arm_o (reload_arm)
   );

   dmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_i),
      .tick_i       (tick),
      .wr_count_i   (wr_count_i),
      .wr_data_i    (wr_data_i),
      .reload_arm_i (reload_arm),
      .reload_i     (reload_val),
      .count_o      (count_o),
      .nxt_o        (nxt),
      .step_o       (step)
   );

   dmt_event #(.CNT_W(CNT_W)) u_evt (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .step_i       (step),
      .nxt_i        (nxt),
      .match_a_i    (match_a),
      .match_b_i    (match_b),
      .ovf_irq_en_i (ovf_irq_en_i),
      .irq_o        (irq_o)
   );

   // R10: disabled channel is fully quiet at its outputs
   p_quiet_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> ($stable(count_o) && $stable(irq_o)));

   // R9: reload write from zero while running loads the count
   p_arm_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reload_arm && !wr_count_i && $past(en_i)) |=> (count_o == $past(wr_data_i)));

endmodule

// File: tb/dmt_channel_tb.sv
module dmt_channel_tb;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0, ext_sel = 1'b0, ovf = 1'b0, ext_tick = 1'b0;
   logic [W-1:0] wdata = '0;
   logic         wr_cnt = 1'b0, wr_rld = 1'b0, wr_ma = 1'b0, wr_mb = 1'b0;
   logic [W-1:0] count;
   logic         irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 clk = ~clk;

   dmt_channel #(.CNT_W(W)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en), .ext_sel_i (ext_sel),
      .ovf_irq_en_i (ovf), .ext_tick_i (ext_tick), .wr_data_i (wdata),
      .wr_count_i (wr_cnt), .wr_reload_i (wr_rld), .wr_match_a_i (wr_ma),
      .wr_match_b_i (wr_mb), .count_o (count), .irq_o (irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // which: 0 count, 1 reload, 2 match A, 3 match B
   task automatic wr(input int which, input logic [W-1:0] v);
      wdata  = v;
      wr_cnt = (which == 0);
      wr_rld = (which == 1);
      wr_ma  = (which == 2);
      wr_mb  = (which == 3);
      step(1);
      {wr_cnt, wr_rld, wr_ma, wr_mb} = '0;
   endtask

   task automatic t_reset;
      chk("R1 count", count, 0);
      chk("R1 irq", irq, 0);
      en = 1'b1;
      step(3);
      chk("R1 reload zero", count, 0);
      chk("R1 irq quiet", irq, 0);
      en = 1'b0;
      step(1);
   endtask

   task automatic t_disabled_writes;
      wr(1, 10);
      chk("R9 reload write while off", count, 0);
      wr(0, 5);
      chk("R8 count write while off", count, 0);
   endtask

   task automatic t_start;
      en = 1'b1;
      step(1);
      chk("R2 start load", count, 10);
      step(3);
      chk("R2 R3 bus decrement", count, 7);
   endtask

   task automatic t_hold;
      logic [W-1:0] c;
      logic         i;
      en = 1'b0;
      step(1);
      c = count;
      i = irq;
      wr(0, 99);
      step(5);
      chk("R10 count hold", count, c);
      chk("R10 irq hold", irq, i);
   endtask

   task automatic t_ext;
      ext_sel = 1'b1;
      en = 1'b1;
      step(1);
      chk("R2 ext start", count, 10);
      step(4);
      chk("R3 no strobe", count, 10);
      ext_tick = 1'b1;
      step(1);
      ext_tick = 1'b0;
      chk("R3 one strobe", count, 9);
      step(3);
      chk("R3 after strobe", count, 9);
   endtask

   task automatic t_writes;
      wr(0, 32'h1234);
      chk("R8 count write", count, 32'h1234);
      wr(1, 50);
      chk("R9 nonzero to nonzero", count, 32'h1234);
      wr(1, 0);
      chk("R9 write zero", count, 32'h1234);
      wr(1, 20);
      chk("R9 zero to nonzero arms", count, 20);
      en = 1'b0;
      ext_sel = 1'b0;
      step(1);
   endtask

   task automatic t_wrap;
      wr(1, 3);
      en = 1'b1;
      step(1);
      chk("R4 start", count, 3);
      step(1); chk("R4 dec", count, 2);
      step(1); chk("R4 dec", count, 1);
      step(1); chk("R4 zero", count, 0);
      step(1); chk("R4 reload", count, 3);
      wr(1, 0);
      wr(0, 2);
      chk("R4 count write", count, 2);
      step(1); chk("R4 dec", count, 1);
      step(1); chk("R4 zero", count, 0);
      step(2); chk("R4 stays zero", count, 0);
      en = 1'b0;
      step(1);
   endtask

   task automatic t_match(input logic [W-1:0] ma, input logic [W-1:0] mb,
                          input logic ov, input string req);
      logic exp_irq;
      en = 1'b0;
      ext_sel = 1'b0;
      wr(1, 9);
      wr(2, ma);
      wr(3, mb);
      ovf = ov;
      exp_irq = irq;
      en = 1'b1;
      step(1);
      chk({req, " start"}, count, 9);
      chk({req, " no event on load"}, irq, exp_irq);
      for (int k = 8; k >= -1; k--) begin
         int unsigned e;
         e = (k < 0) ? 9 : k;
         step(1);
         if (k > 0 && (k == ma || k == mb)) exp_irq = ~exp_irq;
         if (k == 0 && (ov || ma == 0 || mb == 0)) exp_irq = ~exp_irq;
         chk({req, " count"}, count, e);
         chk({req, " R7 irq"}, irq, exp_irq);
      end
      en = 1'b0;
      ovf = 1'b0;
      step(1);
   endtask

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_disabled_writes;
      t_start;
      t_hold;
      t_ext;
      t_writes;
      t_wrap;
      t_match(3, 7, 1'b0, "R5 a<b");
      t_match(7, 3, 1'b0, "R5 a>b");
      t_match(6, 6, 1'b0, "R5 equal");
      t_match(3, 7, 1'b1, "R6 ovf");
      t_match(0, 5, 1'b0, "R6 zero match");
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule